// File: doc/BRIEF.md
# Reset Cause Flag Register

This block is a 16-bit status register that remembers why the most recent system reset happened. Each reset source drives an event input. The block qualifies these events against the supply-domain indications, so that a flag latches only when its own source is the real cause. A flag then stays set through the reset that it describes. The storage answers only to a power-on initialise and is not touched by the ordinary system reset.

Firmware reads the register after start-up to find the reset cause. It clears flags in one of two ways: by writing zeros to them, or as a side effect of the CPU fetching the reset vector word. A failure of the main supply, seen either as a brownout or by the enabled high-side supervisor, erases the deep-sleep wake flag.

Flag positions in the register:
- bit 15: deep-sleep wake
- bit 13: high-side supervisor
- bit 12: core supervisor
- bit 10: software power-on reset
- bit 9: reset pin
- bit 8: software brownout

Top module: `rst_cause_reg`

## Requirements
- R1: While `por` is high, all flags are initialised to 0. A read after power-on returns 0x0000.
- R2: Bits 14, 11 and 7..0 always read as 0 and ignore any value written to them.
- R3: A pulse on `ev_swpor` sets bit 10, a pulse on `ev_pin` sets bit 9, and a pulse on `ev_swbor` sets bit 8.
- R4: Bit 13 sets in a cycle where `hi_sv_en`=1, `main_below_hi`=1 and `main_below_bor`=0. It does not set if either `hi_sv_en` is 0 or `main_below_bor` is 1.
- R5: Bit 12 sets in a cycle where `core_below`=1 and `main_below_hi`=0.
- R6: A pulse on `ev_wake` sets bit 15 when no main-supply failure is present in the same cycle.
- R7: A write (`wr_en`=1) clears every implemented flag whose `wr_data` bit is 0. Flags whose `wr_data` bit is 1 keep their value.
- R8: A single-cycle `vec_fetch` pulse clears all implemented flags.
- R9: A set event in the same cycle as a write-clear or a `vec_fetch` wins, so the flag ends up set.
- R10: `main_below_bor`=1, or `main_below_hi`=1 together with `hi_sv_en`=1, clears bit 15. This clear overrides a wake event in the same cycle.
- R11: A read (`rd_en`=1) returns the flag image on `rd_data` one clock later, and does not change any flag. Without `rd_en`, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on initialise |
| ev_swpor | input | 1 | Software power-on-reset request pulse |
| ev_swbor | input | 1 | Software brownout request pulse |
| ev_pin | input | 1 | External reset pin event pulse |
| ev_wake | input | 1 | Wake from deepest low-power mode pulse |
| main_below_hi | input | 1 | Main supply under high-side threshold |
| main_below_bor | input | 1 | Main supply under brownout threshold |
| core_below | input | 1 | Core voltage under low-side threshold |
| hi_sv_en | input | 1 | High-side supervisor enabled |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data, 0 clears a flag |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 16 | Registered read data |
| vec_fetch | input | 1 | Reset-vector fetch strobe |

## Verification
The assertions assume that `vec_fetch` and the event inputs arrive as single-cycle pulses. They also assume consistent supply indications: a brownout is signalled together with the main supply being under the high-side threshold. The stimulus drives every pulse for exactly one cycle. It always asserts `main_below_hi` whenever it asserts `main_below_bor`. It changes supply levels only between register reads, so each read sees a settled flag image.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int REG_W     = 16;
  localparam int B_WAKE    = 15;
  localparam int B_HISV    = 13;
  localparam int B_LOSV    = 12;
  localparam int B_SWPOR   = 10;
  localparam int B_PIN     = 9;
  localparam int B_SWBOR   = 8;
  localparam logic [REG_W-1:0] IMPL_MASK =
    (REG_W'(1) << B_WAKE)  | (REG_W'(1) << B_HISV) | (REG_W'(1) << B_LOSV) |
    (REG_W'(1) << B_SWPOR) | (REG_W'(1) << B_PIN)  | (REG_W'(1) << B_SWBOR);
  localparam logic [REG_W-1:0] RSVD_MASK = ~IMPL_MASK;
endpackage

// File: rtl/rcf_source_qual.sv
module rcf_source_qual
  import rcf_pkg::*;
(
  input  logic             ev_swpor,
  input  logic             ev_swbor,
  input  logic             ev_pin,
  input  logic             ev_wake,
  input  logic             main_below_hi,
  input  logic             main_below_bor,
  input  logic             core_below,
  input  logic             hi_sv_en,
  output logic [REG_W-1:0] set_vec,
  output logic [REG_W-1:0] kill_vec
);
  logic main_fail;

  always_comb begin
    main_fail = main_below_bor | (main_below_hi & hi_sv_en);
    set_vec = '0;
    set_vec[B_SWPOR] = ev_swpor;
    set_vec[B_SWBOR] = ev_swbor;
    set_vec[B_PIN]   = ev_pin;
    set_vec[B_HISV]  = hi_sv_en & main_below_hi & ~main_below_bor;
    set_vec[B_LOSV]  = core_below & ~main_below_hi;
    set_vec[B_WAKE]  = ev_wake & ~main_fail;
    kill_vec = '0;
    kill_vec[B_WAKE] = main_fail;
  end
endmodule

// File: rtl/rcf_flag_bank.sv
module rcf_flag_bank
  import rcf_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] kill_vec,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             vec_fetch,
  output logic [REG_W-1:0] flags
);
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] nxt;

  always_comb begin
    clr_vec = ({REG_W{wr_en}} & ~wr_data) | {REG_W{vec_fetch}};
    nxt = ((flags & ~clr_vec) | set_vec) & ~kill_vec & IMPL_MASK;
  end

  always_ff @(posedge clk) begin
    if (por) flags <= '0;
    else     flags <= nxt;
  end
endmodule

// File: rtl/rcf_read_port.sv
module rcf_read_port
  import rcf_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic             rd_en,
  input  logic [REG_W-1:0] flags,
  output logic [REG_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (por)        rd_data <= '0;
    else if (rd_en) rd_data <= flags & IMPL_MASK;
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcf_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic             ev_swpor,
  input  logic             ev_swbor,
  input  logic             ev_pin,
  input  logic             ev_wake,
  input  logic             main_below_hi,
  input  logic             main_below_bor,
  input  logic             core_below,
  input  logic             hi_sv_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  input  logic             vec_fetch
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] kill_vec;
  logic [REG_W-1:0] flags;

  rcf_source_qual u_qual (
    .ev_swpor(ev_swpor), .ev_swbor(ev_swbor), .ev_pin(ev_pin), .ev_wake(ev_wake),
    .main_below_hi(main_below_hi), .main_below_bor(main_below_bor),
    .core_below(core_below), .hi_sv_en(hi_sv_en),
    .set_vec(set_vec), .kill_vec(kill_vec)
  );

  rcf_flag_bank u_bank (
    .clk(clk), .por(por), .set_vec(set_vec), .kill_vec(kill_vec),
    .wr_en(wr_en), .wr_data(wr_data), .vec_fetch(vec_fetch), .flags(flags)
  );

  rcf_read_port u_rd (
    .clk(clk), .por(por), .rd_en(rd_en), .flags(flags), .rd_data(rd_data)
  );

  a_r1_por_init: assert property (@(posedge clk) por |=> (flags == '0));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (por)
    (rd_data & RSVD_MASK) == '0);
  a_r8_vec_clears: assert property (@(posedge clk) disable iff (por)
    (vec_fetch && set_vec == '0) |=> (flags == '0));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (por)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
  a_r10_wake_kill: assert property (@(posedge clk) disable iff (por)
    kill_vec[B_WAKE] |=> !flags[B_WAKE]);
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (por)
    !rd_en |=> $stable(rd_data));
  a_r11_rd_image: assert property (@(posedge clk) disable iff (por)
    rd_en |=> (rd_data == $past(flags)));
endmodule

// File: tb/test_rst_cause_reg.sv
module test_rst_cause_reg;
  logic clk = 1'b0;
  logic por = 1'b1;
  logic ev_swpor = 0, ev_swbor = 0, ev_pin = 0, ev_wake = 0;
  logic main_below_hi = 0, main_below_bor = 0, core_below = 0, hi_sv_en = 0;
  logic wr_en = 0, rd_en = 0, vec_fetch = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  int errors = 0;
  int checks = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  rst_cause_reg i_rst_cause_reg (
    .clk(clk), .por(por), .ev_swpor(ev_swpor), .ev_swbor(ev_swbor), .ev_pin(ev_pin),
    .ev_wake(ev_wake), .main_below_hi(main_below_hi), .main_below_bor(main_below_bor),
    .core_below(core_below), .hi_sv_en(hi_sv_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .vec_fetch(vec_fetch)
  );

  // monitor: on a read edge, compare the registered data just after it
  always @(posedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      #1;
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd_expect(input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1;
    tick();
    rd_en = 0;
    tick();
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = '0;
  endtask

  task automatic vfetch();
    vec_fetch = 1; tick(); vec_fetch = 0;
  endtask

  initial begin
    tick(); tick(); tick();
    por = 0;
    rd_expect(16'h0000, "R1 reset state");
    wr(16'hFFFF);
    rd_expect(16'h0000, "R2 reserved ignore writes");
    ev_swpor = 1; tick(); ev_swpor = 0;
    rd_expect(16'h0400, "R3 swpor");
    ev_swbor = 1; tick(); ev_swbor = 0;
    rd_expect(16'h0500, "R3 swbor");
    ev_pin = 1; tick(); ev_pin = 0;
    rd_expect(16'h0700, "R3 pin");
    rd_expect(16'h0700, "R11 read leaves flags");
    wr(16'hFBFF);
    rd_expect(16'h0300, "R7 write zero clears one flag");
    wr(16'hFFFF);
    rd_expect(16'h0300, "R7 write ones keeps");
    vfetch();
    rd_expect(16'h0000, "R8 vector fetch clears");
    hi_sv_en = 1; main_below_hi = 1; tick(); main_below_hi = 0;
    rd_expect(16'h2000, "R4 high-side set");
    vfetch();
    main_below_hi = 1; main_below_bor = 1; tick(); main_below_hi = 0; main_below_bor = 0;
    rd_expect(16'h0000, "R4 no set on brownout");
    hi_sv_en = 0; main_below_hi = 1; tick(); main_below_hi = 0;
    rd_expect(16'h0000, "R4 no set when disabled");
    core_below = 1; tick(); core_below = 0;
    rd_expect(16'h1000, "R5 core set");
    vfetch();
    core_below = 1; main_below_hi = 1; tick(); core_below = 0; main_below_hi = 0;
    rd_expect(16'h0000, "R5 no set under high-side");
    ev_wake = 1; tick(); ev_wake = 0;
    rd_expect(16'h8000, "R6 wake set");
    main_below_hi = 1; main_below_bor = 1; tick(); main_below_hi = 0; main_below_bor = 0;
    rd_expect(16'h0000, "R10 brownout clears wake");
    ev_wake = 1; tick(); ev_wake = 0;
    hi_sv_en = 1; main_below_hi = 1; tick(); main_below_hi = 0;
    rd_expect(16'h2000, "R10 high-side failure clears wake");
    vfetch();
    ev_wake = 1; main_below_hi = 1; main_below_bor = 1; tick();
    ev_wake = 0; main_below_hi = 0; main_below_bor = 0; hi_sv_en = 0;
    rd_expect(16'h0000, "R10 failure beats wake event");
    ev_swpor = 1; wr_en = 1; wr_data = 16'h0000; tick();
    ev_swpor = 0; wr_en = 0;
    rd_expect(16'h0400, "R9 set beats write clear");
    ev_swbor = 1; vec_fetch = 1; tick(); ev_swbor = 0; vec_fetch = 0;
    rd_expect(16'h0100, "R9 set beats vector clear");
    por = 1; tick(); por = 0;
    rd_expect(16'h0000, "R1 power-on init clears");
    tick(); tick();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule